// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block answers a host's interrupt acknowledge cycle. When the active-low acknowledge strobe is seen low at a clock edge, the block picks the interrupt to report and latches it. It looks only at sources that are both pending and enabled, across four channels with five source kinds per channel. It then drives a vector byte onto the host data bus and ends the cycle with a one-clock, active-low acknowledge pulse.

The vector layout is chosen at run time by a 2-bit mode field, which holds bits [1:0] of the interrupt control register. Depending on the mode, the block mixes a varying number of bits from a programmable base vector with the channel number and the interrupt type code. One mode sends no vector at all: the bus enable stays low for the whole cycle, but the acknowledge pulse is still issued.

The block carries no data stream, so every pin is a plain level or strobe and there is no valid/ready back-pressure. The host holds the strobe low until it sees the acknowledge pulse. It releases the strobe afterwards to end the cycle. The bus is modelled as a data output plus an output enable. The data output reads zero whenever the enable is low, and tri-state buffering is left to the pad level.

Top module: `irq_vector_gen`

## Requirements
- R1: While reset is asserted and after it is released, `ack_n` is 1, `vec_oe` is 0 and `vec_data` is 0.
- R2: Mode 2'b00 drives `base_vec[7:0]` unchanged on `vec_data`.
- R3: Mode 2'b01 drives `{base_vec[7:2], channel[1:0]}`.
- R4: Mode 2'b10 drives `{base_vec[7:5], channel[1:0], type[2:0]}`.
- R5: Mode 2'b11 keeps `vec_oe` at 0 and `vec_data` at 0 for the whole cycle, and the acknowledge pulse is still issued with normal timing.
- R6: The clock edge that first samples `iack_n` low is the capture edge. `ack_n` goes low after the ACK_DELAY-th edge that follows the capture edge, and it stays low for exactly one clock.
- R7: `vec_oe` rises after the capture edge (modes 00, 01 and 10). It stays high until an edge after the pulse samples `iack_n` high, and it falls after that edge.
- R8: The channel, type, mode and base bits are latched at the capture edge. Changes to `src_pending`, `src_enable`, `base_vec` or `vec_mode` during the cycle do not change `vec_data`.
- R9: Among channels that have any pending and enabled source, the lowest channel number is reported.
- R10: Within the chosen channel, the kinds rank from the lowest index upward: index 0 receiver (code 3'b001), 1 transmitter (3'b010), 2 break change (3'b011), 3 counter (3'b100), 4 I/O change (3'b101). A source with its `src_enable` bit at 0 is ignored. The bit for channel c and kind k sits at index c*5+k.
- R11: When no source is both pending and enabled, the channel is reported as 0 and the type as 3'b000.
- R12: `vec_data` is 0 whenever `vec_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iack_n | input | 1 | Host interrupt acknowledge strobe, active low |
| vec_mode | input | 2 | Vector format select (interrupt control register bits [1:0]) |
| base_vec | input | 8 | Programmable base vector |
| src_pending | input | 20 | Pending flags, index channel*5+kind |
| src_enable | input | 20 | Per-source enable (1 = may interrupt) |
| vec_data | output | 8 | Vector byte for the host data bus |
| vec_oe | output | 1 | Data bus output enable |
| ack_n | output | 1 | Active-low acknowledge pulse ending the cycle |

## Verification
The bench builds the block with its defaults: NUM_CH=4, NUM_SRC=5 and ACK_DELAY=2. With these values, every channel field value and every type code from 3'b000 to 3'b101 can show up in the vector, so each of the four formats is exercised with all of its fields at full width. The two-edge delay leaves a cycle in which the inputs can be scrambled after capture, before the pulse. Random strobe hold times then stretch the enable window beyond the pulse.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  typedef enum logic [1:0] {
    FMT_BASE = 2'b00,
    FMT_CHAN = 2'b01,
    FMT_TYPE = 2'b10,
    FMT_NONE = 2'b11
  } vec_fmt_e;

  localparam int VEC_W      = 8;
  localparam int CH_FIELD_W = 2;
  localparam int TYPE_W     = 3;

endpackage

// File: rtl/irq_src_arbiter.sv
module irq_src_arbiter
  import irq_vec_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_SRC = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH*NUM_SRC-1:0] pend_i,
  input  logic [NUM_CH*NUM_SRC-1:0] en_i,
  output logic [CH_FIELD_W-1:0]     ch_o,
  output logic [TYPE_W-1:0]         ty_o,
  output logic                      any_o
);

  localparam int TOTAL = NUM_CH * NUM_SRC;

  logic [TOTAL-1:0]                 live;
  logic [NUM_CH-1:0]                ch_any;
  logic [NUM_CH-1:0][TYPE_W-1:0]    ch_ty;
  logic [NUM_CH-1:0]                grant;

  assign live = pend_i & en_i;

  function automatic logic [TYPE_W-1:0] first_code(input logic [NUM_SRC-1:0] v);
    logic [TYPE_W-1:0] code;
    code = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--)
      if (v[k]) code = TYPE_W'(k + 1);
    return code;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign ch_any[c] = |live[c*NUM_SRC +: NUM_SRC];
    assign ch_ty[c]  = first_code(live[c*NUM_SRC +: NUM_SRC]);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_any[c] && !found) begin
        grant[c] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    ch_o = '0;
    ty_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (grant[c]) begin
        ch_o = CH_FIELD_W'(c);
        ty_o = ch_ty[c];
      end
    end
  end

  assign any_o = |ch_any;

  int pick_idx;
  assign pick_idx = int'(ch_o) * NUM_SRC + int'(ty_o) - 1;

  AST_PICK_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (pend_i[pick_idx] && en_i[pick_idx]));  // R10
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_o |-> (ty_o == '0 && ch_o == '0));  // R11
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));  // R9

endmodule

// File: rtl/irq_vec_format.sv
module irq_vec_format
  import irq_vec_pkg::*;
(
  input  vec_fmt_e              fmt_i,
  input  logic [VEC_W-1:0]      base_i,
  input  logic [CH_FIELD_W-1:0] ch_i,
  input  logic [TYPE_W-1:0]     ty_i,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  drive_o
);

  always_comb begin
    drive_o = 1'b1;
    unique case (fmt_i)
      FMT_BASE: vec_o = base_i;
      FMT_CHAN: vec_o = {base_i[VEC_W-1:CH_FIELD_W], ch_i};
      FMT_TYPE: vec_o = {base_i[VEC_W-1:CH_FIELD_W+TYPE_W], ch_i, ty_i};
      default: begin
        vec_o   = '0;
        drive_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int ACK_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic iack_n,
  output logic capture_o,
  output logic release_o,
  output logic busy_o,
  output logic ack_n
);

  localparam int CNT_W = $clog2(ACK_DELAY + 1);

  logic             busy;
  logic             done;
  logic [CNT_W-1:0] cnt;

  assign capture_o = !busy && !iack_n;
  assign release_o = busy && done && iack_n;
  assign busy_o    = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      ack_n <= 1'b1;
    end else begin
      ack_n <= 1'b1;
      if (capture_o) begin
        busy <= 1'b1;
        done <= 1'b0;
        cnt  <= CNT_W'(1);
      end else if (busy && !done) begin
        if (cnt == CNT_W'(ACK_DELAY)) begin
          ack_n <= 1'b0;
          done  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (release_o) begin
        busy <= 1'b0;
      end
    end
  end

  AST_ACK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n);  // R6
  AST_ACK_INSIDE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> busy);  // R6
  AST_ACK_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !$past(iack_n));  // R6

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import irq_vec_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_SRC   = 5,
  parameter int ACK_DELAY = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iack_n,
  input  logic [1:0]                vec_mode,
  input  logic [VEC_W-1:0]          base_vec,
  input  logic [NUM_CH*NUM_SRC-1:0] src_pending,
  input  logic [NUM_CH*NUM_SRC-1:0] src_enable,
  output logic [VEC_W-1:0]          vec_data,
  output logic                      vec_oe,
  output logic                      ack_n
);

  logic [CH_FIELD_W-1:0] sel_ch;
  logic [TYPE_W-1:0]     sel_ty;
  logic                  sel_any;
  logic [VEC_W-1:0]      fmt_vec;
  logic                  fmt_drive;
  logic                  capture, release_c, busy;
  vec_fmt_e              mode_e;

  assign mode_e = vec_fmt_e'(vec_mode);

  irq_src_arbiter #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(src_pending), .en_i(src_enable),
    .ch_o(sel_ch), .ty_o(sel_ty), .any_o(sel_any)
  );

  irq_vec_format u_fmt (
    .fmt_i(mode_e), .base_i(base_vec), .ch_i(sel_ch), .ty_i(sel_ty),
    .vec_o(fmt_vec), .drive_o(fmt_drive)
  );

  irq_ack_seq #(.ACK_DELAY(ACK_DELAY)) u_seq (
    .clk(clk), .rst_n(rst_n), .iack_n(iack_n), .capture_o(capture),
    .release_o(release_c), .busy_o(busy), .ack_n(ack_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_data <= '0;
      vec_oe   <= 1'b0;
    end else if (capture) begin
      vec_data <= fmt_drive ? fmt_vec : '0;
      vec_oe   <= fmt_drive;
    end else if (release_c) begin
      vec_data <= '0;
      vec_oe   <= 1'b0;
    end
  end

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_oe |-> vec_data == '0);  // R12
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe && $past(vec_oe)) |-> $stable(vec_data));  // R8
  AST_NO_VEC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && vec_mode == 2'b11) |=> !vec_oe);  // R5
  AST_OE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> busy);  // R7
  AST_ANY_MATCHES_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_any == (sel_ty != '0));  // R11

endmodule

// File: tb/irq_vector_gen_test.sv
`timescale 1ns/1ps
module irq_vector_gen_test;

  localparam int NUM_CH    = 4;
  localparam int NUM_SRC   = 5;
  localparam int ACK_DELAY = 2;
  localparam int TOT       = NUM_CH * NUM_SRC;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           iack_n;
  logic [1:0]     vec_mode;
  logic [7:0]     base_vec;
  logic [TOT-1:0] src_pending, src_enable;
  logic [7:0]     vec_data;
  logic           vec_oe, ack_n;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  irq_vector_gen #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .ACK_DELAY(ACK_DELAY)) uut (
    .clk(clk), .rst_n(rst_n), .iack_n(iack_n), .vec_mode(vec_mode),
    .base_vec(base_vec), .src_pending(src_pending), .src_enable(src_enable),
    .vec_data(vec_data), .vec_oe(vec_oe), .ack_n(ack_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_pick(input logic [TOT-1:0] p, input logic [TOT-1:0] e);
    for (int c = 0; c < NUM_CH; c++)
      for (int k = 0; k < NUM_SRC; k++)
        if (p[c*NUM_SRC+k] && e[c*NUM_SRC+k]) return {2'(c), 3'(k + 1)};
    return 5'b0;
  endfunction

  function automatic logic [7:0] exp_vec(input logic [1:0] m, input logic [7:0] b, input logic [4:0] ct);
    case (m)
      2'b00:   return b;
      2'b01:   return {b[7:2], ct[4:3]};
      2'b10:   return {b[7:5], ct[4:3], ct[2:0]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_iack(input logic [1:0] m, input logic [7:0] b, input logic [TOT-1:0] p,
                          input logic [TOT-1:0] e, input int hold, input bit scramble, input string dtag);
    logic [7:0] ev;
    logic       eoe;
    @(negedge clk);
    vec_mode = m; base_vec = b; src_pending = p; src_enable = e; iack_n = 1'b0;
    eoe = (m != 2'b11);
    ev  = exp_vec(m, b, exp_pick(p, e));
    @(negedge clk);
    chk(vec_oe == eoe, eoe ? "R7" : "R5", 32'(vec_oe), 32'(eoe));
    chk(vec_data == ev, mode_tag(m), 32'(vec_data), 32'(ev));
    chk(vec_data == ev, dtag, 32'(vec_data), 32'(ev));
    chk(ack_n == 1'b1, "R6", 32'(ack_n), 32'd1);
    if (scramble) begin
      src_pending = TOT'($urandom); src_enable = TOT'($urandom);
      base_vec = 8'($urandom); vec_mode = 2'($urandom);
    end
    for (int i = 1; i < ACK_DELAY; i++) begin
      @(negedge clk);
      chk(ack_n == 1'b1, "R6", 32'(ack_n), 32'd1);
      chk(vec_data == ev, "R8", 32'(vec_data), 32'(ev));
    end
    @(negedge clk);
    chk(ack_n == 1'b0, eoe ? "R6" : "R5", 32'(ack_n), 32'd0);
    chk(vec_data == ev && vec_oe == eoe, "R8", 32'(vec_data), 32'(ev));
    @(negedge clk);
    chk(ack_n == 1'b1, "R6", 32'(ack_n), 32'd1);
    for (int i = 0; i < hold; i++) begin
      chk(vec_oe == eoe, "R7", 32'(vec_oe), 32'(eoe));
      @(negedge clk);
      chk(ack_n == 1'b1, "R6", 32'(ack_n), 32'd1);
    end
    chk(vec_oe == eoe, "R7", 32'(vec_oe), 32'(eoe));
    iack_n = 1'b1;
    @(negedge clk);
    chk(vec_oe == 1'b0, "R7", 32'(vec_oe), 32'd0);
    chk(vec_data == 8'h00, "R12", 32'(vec_data), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; iack_n = 1'b1; vec_mode = 2'b00; base_vec = 8'h00;
    src_pending = '0; src_enable = '0;
    repeat (3) @(negedge clk);
    chk(ack_n == 1'b1 && vec_oe == 1'b0 && vec_data == 8'h00, "R1",
        {22'd0, ack_n, vec_oe, vec_data}, 32'h200);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ack_n == 1'b1 && vec_oe == 1'b0 && vec_data == 8'h00, "R1",
        {22'd0, ack_n, vec_oe, vec_data}, 32'h200);

    // Directed: each format with channel 2 counter (type 100)
    run_iack(2'b00, 8'hA5, TOT'(1) << 13, '1, 0, 0, "R2");
    run_iack(2'b01, 8'hA5, TOT'(1) << 13, '1, 0, 0, "R3");
    run_iack(2'b10, 8'hA5, TOT'(1) << 13, '1, 0, 0, "R4");
    run_iack(2'b11, 8'hA5, TOT'(1) << 13, '1, 2, 0, "R5");
    // R9: channels 1 and 3 pending, lowest wins
    run_iack(2'b10, 8'hE0, (TOT'(1) << 19) | (TOT'(1) << 9), '1, 0, 0, "R9");
    // R10: ch0 receiver pending but disabled, transmitter pending -> type 010
    run_iack(2'b10, 8'h00, TOT'(3), ~TOT'(1), 0, 0, "R10");
    // R10: all kinds of ch3 pending, receiver wins -> type 001
    run_iack(2'b10, 8'h1F, TOT'(5'h1F) << 15, '1, 0, 0, "R10");
    // R11: nothing enabled -> channel 0 type 000
    run_iack(2'b10, 8'hFF, '1, '0, 1, 0, "R11");
    // R8: inputs scrambled after capture
    run_iack(2'b01, 8'h3C, TOT'(1) << 7, '1, 1, 1, "R8");

    for (int it = 0; it < 300; it++)
      run_iack(2'($urandom), 8'($urandom), TOT'($urandom), TOT'($urandom),
               int'($urandom % 4), ($urandom % 2) == 1, "R9");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule